// File: doc/BRIEF.md
# Dual-Zone NAND Read Model

This block models a read-only NAND-style flash that sits behind two chip-enable zones and shares one byte-wide bidirectional data bus. The host drives the parallel flash control lines: an active-low chip enable for each zone, active-low read and write strobes, and latch enables for commands and addresses. The block captures commands and address bytes on the rising edge of the write strobe. It then serves one byte for each read strobe from a per-zone internal array.

Every control input passes through a synchroniser into the system clock domain, so all decisions are made on registered copies of the pins. Each zone keeps its own mode, address-cycle count and byte address, so the host can alternate between zones without losing its place in either one. The device never reports busy. Protocol misuse raises a sticky error flag and otherwise leaves the model untouched.

The arrays are built from flops that are loaded during reset. One parameter chooses erased contents (every byte 0xFF). The other setting loads a test pattern that a bench can predict. Addresses beyond the array depth wrap.

Top module: `nrm_top`

## Requirements
- R1: Zone 0 is selected while `ce_n[0]` is low, whatever `ce_n[1]` is. Zone 1 is selected only while `ce_n[0]` is high and `ce_n[1]` is low. With both enables high, nothing on the bus has any effect: no error, no output drive, and no change to either zone's mode or address.
- R2: While a zone is selected and both strobes are high, `dq` is released (high impedance) and only that zone's bit of `rdy` is high. `rdy` is all zero when no zone is selected or when any strobe is low.
- R3: A rising edge of `we_n` with `cle` high and `ale` low is a command. 0x00, 0x01 and 0x50 enter read modes A, B and C, and each of them restarts the address-byte count. 0xFF puts the zone back in idle.
- R4: The first address byte after a read command (rising `we_n` with `ale` high and `cle` low) replaces the byte address with the byte value. It ORs in 0x100 in mode B and 0x200 in mode C.
- R5: The second address byte adds byte×135168 (that is, 528×256) to the address, and the third adds byte×528.
- R6: While a zone is selected, `re_n` is low, `we_n` is high and both latch enables are low, `dq` carries the array byte at the zone's address modulo the depth. Each rising edge of `re_n` under those conditions advances the address by one.
- R7: With erased contents every array byte reads 0xFF. With pattern contents, the byte at index i of zone z is i[7:0] XOR (i>>8)[7:0], further XORed with 0xA5 for zone 1.
- R8: The following errors set `err` and change no mode or address: an unknown command, a fourth address byte, an address byte while idle, a `we_n` rise with both or neither latch high, a strobe rise while the other strobe is low, and an `re_n` rise with a latch high.
- R9: After reset `err` is 0, both zones are idle at address 0, and `dq` is released. Once set, `err` stays high until reset.
- R10: Each zone's mode and address persist across the other zone's accesses.
- R11: The array index is the low log2(DEPTH) bits of the address, so reading past index DEPTH−1 continues at index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 2 | Active-low zone enables, bit 0 has priority |
| re_n | input | 1 | Active-low read strobe |
| we_n | input | 1 | Active-low write strobe |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| dq | inout | 8 | Shared data bus, driven by the block only during reads |
| rdy | output | 2 | Per-zone ready indication |
| err | output | 1 | Sticky protocol-error flag |

## Verification
The hardest situation to reach is proving that a rejected operation left no trace. The model's mode and address are internal, so the only way to see them is through later legal traffic. After each illegal operation the stimulus continues the normal sequence. For example, it sends the remaining address bytes after a rejected command, or it reads straight after a rejected fourth address byte. The byte returned then shows whether the count or the address moved. A long address sequence in mode C is chosen so that it lands on the last array index, and two reads then show the wrap to index 0.

// File: rtl/nrm_pkg.sv
package nrm_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_A    = 2'd1,
        MODE_B    = 2'd2,
        MODE_C    = 2'd3
    } nrm_mode_e;

    localparam logic [7:0] OP_GO_IDLE = 8'hFF;
    localparam logic [7:0] OP_MODE_A  = 8'h00;
    localparam logic [7:0] OP_MODE_B  = 8'h01;
    localparam logic [7:0] OP_MODE_C  = 8'h50;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;
    localparam logic [7:0] ZONE1_SALT  = 8'hA5;

    // Reset-time content of one array cell
    function automatic logic [7:0] fill_byte(input bit pat, input bit zone, input int unsigned idx);
        logic [7:0] v;
        if (!pat) begin
            v = ERASED_BYTE;
        end else begin
            v = 8'(idx) ^ 8'(idx >> 8);
            if (zone) v = v ^ ZONE1_SALT;
        end
        return v;
    endfunction

endpackage

// File: rtl/nrm_sync.sv
module nrm_sync #(
    parameter int              WIDTH   = 8,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] pipe_q;
    logic [STAGES-1:0][WIDTH-1:0] pipe_d;

    always_comb begin
        pipe_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                pipe_q[s] <= RST_VAL;
            end
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/nrm_zone.sv
module nrm_zone
    import nrm_pkg::*;
#(
    parameter int ADDR_W      = 26,
    parameter int DEPTH       = 1024,
    parameter int PAGE_BYTES  = 528,
    parameter int ZONE_ID     = 0,
    parameter bit PRELOAD_PAT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_ev,
    input  logic              addr_ev,
    input  logic              adv_ev,
    input  logic [7:0]        din,
    output logic [ADDR_W-1:0] addr,
    output logic [7:0]        rd_byte,
    output logic              err_ev
);

    localparam int              IDX_W    = $clog2(DEPTH);
    localparam logic [ADDR_W-1:0] ROW_STEP = ADDR_W'(PAGE_BYTES * 256);
    localparam logic [ADDR_W-1:0] PG_STEP  = ADDR_W'(PAGE_BYTES);
    localparam logic [ADDR_W-1:0] BASE_B   = ADDR_W'(16'h0100);
    localparam logic [ADDR_W-1:0] BASE_C   = ADDR_W'(16'h0200);

    typedef struct packed {
        nrm_mode_e         mode;
        logic [1:0]        cyc;
        logic [ADDR_W-1:0] addr;
    } zone_st_t;

    zone_st_t cur_q, nxt_d;
    logic     err_d;

    logic [7:0] mem_q [DEPTH];

    function automatic logic [ADDR_W-1:0] col_base(input nrm_mode_e m);
        case (m)
            MODE_B:  return BASE_B;
            MODE_C:  return BASE_C;
            default: return '0;
        endcase
    endfunction

    always_comb begin
        nxt_d = cur_q;
        err_d = 1'b0;
        if (cmd_ev) begin
            case (din)
                OP_GO_IDLE: nxt_d.mode = MODE_IDLE;
                OP_MODE_A: begin
                    nxt_d.mode = MODE_A;
                    nxt_d.cyc  = 2'd0;
                end
                OP_MODE_B: begin
                    nxt_d.mode = MODE_B;
                    nxt_d.cyc  = 2'd0;
                end
                OP_MODE_C: begin
                    nxt_d.mode = MODE_C;
                    nxt_d.cyc  = 2'd0;
                end
                default: err_d = 1'b1;
            endcase
        end else if (addr_ev) begin
            if (cur_q.mode == MODE_IDLE || cur_q.cyc == 2'd3) begin
                err_d = 1'b1;
            end else begin
                case (cur_q.cyc)
                    2'd0:    nxt_d.addr = ADDR_W'(din) | col_base(cur_q.mode);
                    2'd1:    nxt_d.addr = cur_q.addr + ADDR_W'(din) * ROW_STEP;
                    default: nxt_d.addr = cur_q.addr + ADDR_W'(din) * PG_STEP;
                endcase
                nxt_d.cyc = cur_q.cyc + 2'd1;
            end
        end else if (adv_ev) begin
            nxt_d.addr = cur_q.addr + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.mode <= MODE_IDLE;
            cur_q.cyc  <= 2'd0;
            cur_q.addr <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    // Read-only contents, loaded while reset is active
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int unsigned i = 0; i < DEPTH; i++) begin
                mem_q[i] <= fill_byte(PRELOAD_PAT, ZONE_ID != 0, i);
            end
        end
    end

    assign addr    = cur_q.addr;
    assign rd_byte = mem_q[cur_q.addr[IDX_W-1:0]];
    assign err_ev  = err_d;

endmodule

// File: rtl/nrm_top.sv
module nrm_top
    import nrm_pkg::*;
#(
    parameter int ADDR_W      = 26,
    parameter int DEPTH       = 1024,
    parameter int PAGE_BYTES  = 528,
    parameter int SYNC_STAGES = 2,
    parameter bit PRELOAD_PAT = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ce_n,
    input  logic       re_n,
    input  logic       we_n,
    input  logic       cle,
    input  logic       ale,
    inout  wire  [7:0] dq,
    output logic [1:0] rdy,
    output logic       err
);

    localparam int NZONE = 2;
    localparam int SYN_W = NZONE + 4 + 8;

    typedef struct packed {
        logic re_p;
        logic we_p;
        logic err;
    } top_st_t;

    top_st_t cur_q, nxt_d;

    logic [SYN_W-1:0] syn_out;
    logic [1:0]       ce_s;
    logic             re_s, we_s, cle_s, ale_s;
    logic [7:0]       dq_s;

    logic [NZONE-1:0] sel;
    logic             any_sel, we_rise, re_rise;
    logic             cmd_hit, addr_hit, adv_hit, bus_err;
    logic [NZONE-1:0] cmd_ev, addr_ev, adv_ev, zone_err;
    logic             oe;
    logic [7:0]       out_byte;

    logic [ADDR_W-1:0] zone_addr [NZONE];
    logic [7:0]        zone_byte [NZONE];

    nrm_sync #(
        .WIDTH  (SYN_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL({{(NZONE + 2){1'b1}}, 2'b00, 8'h00})
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ce_n, re_n, we_n, cle, ale, dq}),
        .dout (syn_out)
    );

    assign {ce_s, re_s, we_s, cle_s, ale_s, dq_s} = syn_out;

    always_comb begin
        sel[0]   = ~ce_s[0];
        sel[1]   = ce_s[0] & ~ce_s[1];
        any_sel  = |sel;
        we_rise  = we_s & ~cur_q.we_p;
        re_rise  = re_s & ~cur_q.re_p;

        cmd_hit  = 1'b0;
        addr_hit = 1'b0;
        adv_hit  = 1'b0;
        bus_err  = 1'b0;

        if (any_sel && we_rise) begin
            if (!re_s || (cle_s == ale_s)) bus_err = 1'b1;
            else if (cle_s)                 cmd_hit = 1'b1;
            else                            addr_hit = 1'b1;
        end
        if (any_sel && re_rise) begin
            if (!we_s || cle_s || ale_s) bus_err = 1'b1;
            else                         adv_hit = 1'b1;
        end

        cmd_ev   = sel & {NZONE{cmd_hit}};
        addr_ev  = sel & {NZONE{addr_hit}};
        adv_ev   = sel & {NZONE{adv_hit}};

        oe       = any_sel & ~re_s & we_s & ~cle_s & ~ale_s;
        rdy      = sel & {NZONE{re_s & we_s}};
        out_byte = sel[0] ? zone_byte[0] : zone_byte[1];

        nxt_d.re_p = re_s;
        nxt_d.we_p = we_s;
        nxt_d.err  = cur_q.err | bus_err | (|zone_err);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.re_p <= 1'b1;
            cur_q.we_p <= 1'b1;
            cur_q.err  <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    for (genvar z = 0; z < NZONE; z++) begin : g_zone
        nrm_zone #(
            .ADDR_W     (ADDR_W),
            .DEPTH      (DEPTH),
            .PAGE_BYTES (PAGE_BYTES),
            .ZONE_ID    (z),
            .PRELOAD_PAT(PRELOAD_PAT)
        ) u_zone (
            .clk    (clk),
            .rst_n  (rst_n),
            .cmd_ev (cmd_ev[z]),
            .addr_ev(addr_ev[z]),
            .adv_ev (adv_ev[z]),
            .din    (dq_s),
            .addr   (zone_addr[z]),
            .rd_byte(zone_byte[z]),
            .err_ev (zone_err[z])
        );
    end

    assign dq  = oe ? out_byte : 8'hzz;
    assign err = cur_q.err;

endmodule

// File: rtl/nrm_chk.sv
module nrm_chk #(
    parameter int ADDR_W = 26
) (
    input logic              clk,
    input logic              rst_n,
    input logic              err,
    input logic [1:0]        rdy,
    input logic              oe,
    input logic              re_s,
    input logic [1:0]        sel,
    input logic [1:0]        zone_err,
    input logic [ADDR_W-1:0] addr0,
    input logic [ADDR_W-1:0] addr1
);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R2
    rdy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rdy));

    // R2
    drive_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> (rdy == 2'b00));

    // R6
    drive_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> !re_s);

    // R8
    reject_hold0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zone_err[0] |=> $stable(addr0));

    // R8
    reject_hold1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zone_err[1] |=> $stable(addr1));

    // R10
    idle_zone0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel[0] |=> $stable(addr0));

    // R10
    idle_zone1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel[1] |=> $stable(addr1));

    // R8
    err_only_when_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b00 && !err) |=> !err);

endmodule

bind nrm_top nrm_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .err     (err),
    .rdy     (rdy),
    .oe      (oe),
    .re_s    (re_s),
    .sel     (sel),
    .zone_err(zone_err),
    .addr0   (zone_addr[0]),
    .addr1   (zone_addr[1])
);

// File: tb/nrm_top_test.sv
module nrm_top_test;

    localparam int TB_DEPTH = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ce_n = 2'b11;
    logic       re_n = 1'b1;
    logic       we_n = 1'b1;
    logic       cle = 1'b0;
    logic       ale = 1'b0;
    logic       tb_oe = 1'b0;
    logic [7:0] tb_dq = 8'h00;
    wire  [7:0] dq_a;
    wire  [7:0] dq_b;
    logic [1:0] rdy_a, rdy_b;
    logic       err_a, err_b;

    assign dq_a = tb_oe ? tb_dq : 8'hzz;
    assign dq_b = tb_oe ? tb_dq : 8'hzz;

    always #5 clk = ~clk;

    nrm_top #(.PRELOAD_PAT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .re_n(re_n), .we_n(we_n),
        .cle(cle), .ale(ale), .dq(dq_a), .rdy(rdy_a), .err(err_a)
    );

    nrm_top #(.PRELOAD_PAT(1'b0)) uut_blank (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .re_n(re_n), .we_n(we_n),
        .cle(cle), .ale(ale), .dq(dq_b), .rdy(rdy_b), .err(err_b)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // independent model of each zone
    int unsigned m_addr [2];
    int          m_mode [2];
    int          m_cyc  [2];

    // scoreboard
    logic [7:0] exp_q [$];
    string      tag_q [$];
    event       smp_ev;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    function automatic logic [7:0] pat_byte(input int zone, input int unsigned a);
        int unsigned idx;
        logic [7:0]  v;
        idx = a % TB_DEPTH;
        v = 8'(idx) ^ 8'(idx >> 8);
        if (zone == 1) v = v ^ 8'hA5;
        return v;
    endfunction

    function automatic int cur_zone();
        if (!ce_n[0]) return 0;
        if (!ce_n[1]) return 1;
        return -1;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(3);
        for (int z = 0; z < 2; z++) begin
            m_addr[z] = 0;
            m_mode[z] = 0;
            m_cyc[z]  = 0;
        end
    endtask

    task automatic select(input logic [1:0] v);
        ce_n = v;
        tick(4);
    endtask

    task automatic wr(input logic c, input logic a, input logic [7:0] b);
        cle = c; ale = a; tb_dq = b; tb_oe = 1'b1;
        tick(3);
        we_n = 1'b0;
        tick(4);
        we_n = 1'b1;
        tick(4);
        cle = 1'b0; ale = 1'b0; tb_oe = 1'b0;
        tick(2);
    endtask

    task automatic cmd(input logic [7:0] b);
        int z;
        z = cur_zone();
        wr(1'b1, 1'b0, b);
        if (z >= 0) begin
            case (b)
                8'h00: begin m_mode[z] = 1; m_cyc[z] = 0; end
                8'h01: begin m_mode[z] = 2; m_cyc[z] = 0; end
                8'h50: begin m_mode[z] = 3; m_cyc[z] = 0; end
                8'hFF: m_mode[z] = 0;
                default: ;
            endcase
        end
    endtask

    task automatic adr(input logic [7:0] b);
        int z;
        z = cur_zone();
        wr(1'b0, 1'b1, b);
        if (z >= 0) begin
            case (m_cyc[z])
                0: m_addr[z] = b | (m_mode[z] == 2 ? 32'h100 : m_mode[z] == 3 ? 32'h200 : 32'h0);
                1: m_addr[z] = m_addr[z] + b * 135168;
                default: m_addr[z] = m_addr[z] + b * 528;
            endcase
            m_cyc[z]++;
        end
    endtask

    task automatic rd(input string req);
        int z;
        z = cur_zone();
        exp_q.push_back(pat_byte(z, m_addr[z]));
        tag_q.push_back(req);
        re_n = 1'b0;
        tick(5);
        -> smp_ev;
        check(dq_b === 8'hFF, "R7 erased byte", {24'h0, dq_b}, 32'hFF);
        check(rdy_a === 2'b00, "R2 ready low during read", {30'h0, rdy_a}, 32'h0);
        tick(1);
        re_n = 1'b1;
        tick(5);
        m_addr[z] = m_addr[z] + 1;
    endtask

    // monitor
    initial begin
        forever begin
            @(smp_ev);
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected sample", {24'h0, dq_a}, 32'h0);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(dq_a === e, t, {24'h0, dq_a}, {24'h0, e});
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        do_reset();

        // R9 reset state
        check(err_a === 1'b0, "R9 err after reset", {31'h0, err_a}, 32'h0);
        check(dq_a === 8'hzz, "R9 bus released after reset", {24'h0, dq_a}, 32'h0);
        check(rdy_a === 2'b00, "R2 no ready without enable", {30'h0, rdy_a}, 32'h0);

        select(2'b10);
        check(rdy_a === 2'b01, "R2 zone0 ready", {30'h0, rdy_a}, 32'h1);
        check(dq_a === 8'hzz, "R2 bus released when idle", {24'h0, dq_a}, 32'h0);
        rd("R9 idle read at address zero");

        // R3 R4 mode A
        cmd(8'h00); adr(8'h05); adr(8'h00); adr(8'h00);
        rd("R6 mode A read"); rd("R6 advance"); rd("R6 advance again");

        // R4 R5 mode B with page step
        cmd(8'h01); adr(8'h10); adr(8'h00); adr(8'h01);
        rd("R5 mode B page step"); rd("R6 mode B advance");

        // R5 R11 mode C with row step and wrap
        cmd(8'h50); adr(8'h02); adr(8'h01); adr(8'h00);
        rd("R5 mode C row step");
        cmd(8'h50); adr(8'hFF); adr(8'h00); adr(8'h10);
        rd("R11 last index"); rd("R11 wrap to index zero");

        // R1 R10 zone 1
        select(2'b01);
        check(rdy_a === 2'b10, "R2 zone1 ready", {30'h0, rdy_a}, 32'h2);
        cmd(8'h00); adr(8'h07); adr(8'h00); adr(8'h00);
        rd("R7 zone1 pattern"); rd("R7 zone1 advance");
        select(2'b10);
        rd("R10 zone0 resumes");
        select(2'b00);
        check(rdy_a === 2'b01, "R1 zone0 priority ready", {30'h0, rdy_a}, 32'h1);
        rd("R1 zone0 priority read");
        select(2'b01);
        rd("R10 zone1 resumes");

        // R1 deselected bus ignored
        select(2'b11);
        wr(1'b1, 1'b0, 8'h90);
        wr(1'b0, 1'b1, 8'h33);
        re_n = 1'b0; tick(5);
        check(dq_a === 8'hzz, "R1 no drive when deselected", {24'h0, dq_a}, 32'h0);
        re_n = 1'b1; tick(5);
        check(err_a === 1'b0, "R1 no error when deselected", {31'h0, err_a}, 32'h0);
        check(rdy_a === 2'b00, "R1 no ready when deselected", {30'h0, rdy_a}, 32'h0);
        select(2'b10);
        rd("R1 zone0 untouched while deselected");
        check(err_a === 1'b0, "R8 no error on legal traffic", {31'h0, err_a}, 32'h0);

        // R8 fourth address byte
        cmd(8'h00); adr(8'h05); adr(8'h00); adr(8'h00);
        wr(1'b0, 1'b1, 8'h33);
        check(err_a === 1'b1, "R8 fourth address byte flagged", {31'h0, err_a}, 32'h1);
        rd("R8 address kept after fourth byte");
        cmd(8'h00);
        check(err_a === 1'b1, "R9 err sticky", {31'h0, err_a}, 32'h1);
        do_reset();
        check(err_a === 1'b0, "R9 err cleared by reset", {31'h0, err_a}, 32'h0);
        select(2'b10);
        rd("R9 address zero after reset");

        // R8 unknown command keeps mode and byte count
        cmd(8'h00); adr(8'h20);
        wr(1'b1, 1'b0, 8'h90);
        check(err_a === 1'b1, "R8 unknown command flagged", {31'h0, err_a}, 32'h1);
        adr(8'h00); adr(8'h00);
        rd("R8 count kept after unknown command");
        do_reset();
        select(2'b10);

        // R8 address byte while idle
        cmd(8'h00); adr(8'h09); adr(8'h00); adr(8'h00);
        cmd(8'hFF);
        wr(1'b0, 1'b1, 8'h44);
        check(err_a === 1'b1, "R8 idle address flagged", {31'h0, err_a}, 32'h1);
        rd("R8 address kept after idle address");
        do_reset();
        select(2'b10);

        // R8 both latches high on write edge
        cmd(8'h00); adr(8'h0C); adr(8'h00); adr(8'h00);
        wr(1'b1, 1'b1, 8'h00);
        check(err_a === 1'b1, "R8 both latches flagged", {31'h0, err_a}, 32'h1);
        rd("R8 address kept after both latches");
        do_reset();
        select(2'b10);

        // R8 read edge with command latch high
        cmd(8'h00); adr(8'h11); adr(8'h00); adr(8'h00);
        cle = 1'b1; tick(3);
        re_n = 1'b0; tick(4);
        re_n = 1'b1; tick(4);
        cle = 1'b0; tick(3);
        check(err_a === 1'b1, "R8 read with latch flagged", {31'h0, err_a}, 32'h1);
        rd("R8 no advance on bad read edge");

        tick(4);
        check(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 32'h0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule